// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised storage register (eight bits by default) that can hold its contents, shift toward its high end, shift toward its low end, or capture a full word in parallel. Its data pins are shared between input and output. Each bit is therefore modelled as three separate signals: a pad input, a pad output and a pad output enable. A pad wrapper at the chip edge combines them into a true bidirectional pin.

A two-bit mode input picks the operation. Two active-low enables gate the pad drivers. Parallel load always turns the drivers off, so that outside data can be sampled on the shared pins. An active-low clear zeroes the register at once, without waiting for the clock. Two serial inputs feed the vacant end bit in the shift modes. Two serial taps expose the end bits at all times, so several copies can be chained into a longer word that shifts in either direction.

Top module: `univ_shreg`

## Requirements
- R1: With mode 2'b00 the stored word does not change on a rising clock.
- R2: With mode 2'b01 a rising clock moves each bit i to bit i+1, and bit 0 takes `ser_rt`.
- R3: With mode 2'b10 a rising clock moves each bit i to bit i-1, and bit W-1 takes `ser_lf`.
- R4: With mode 2'b11 every `pad_oe` bit is 0 whatever the enables are, and a rising clock stores `pad_in`.
- R5: Every `pad_oe` bit is 1 exactly when `en_a_n` and `en_b_n` are both 0 and the mode is not 2'b11. Otherwise every bit is 0. `pad_out` always carries the stored word.
- R6: The enables have no effect on the stored word in any mode, including while clear is active.
- R7: While `clr_n` is 0 the stored word is zero at once, with no clock edge needed, whatever the mode and enables are. Clock edges that arrive while `clr_n` is 0 are ignored.
- R8: `tap_lo` always equals stored bit 0 and `tap_hi` always equals stored bit W-1. Neither tap depends on the enables.
- R9: The first rising clock after `clr_n` returns to 1 acts on an all-zero word.
- R10: Two instances chained tap-to-serial-input behave as one 2W-bit register in both shift directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| en_a_n | input | 1 | Pad driver enable, active low |
| en_b_n | input | 1 | Second pad driver enable, active low |
| ser_rt | input | 1 | Serial input into bit 0 when shifting up |
| ser_lf | input | 1 | Serial input into bit W-1 when shifting down |
| pad_in | input | W | Values seen on the shared pins |
| pad_out | output | W | Stored word driven toward the shared pins |
| pad_oe | output | W | Per-bit pad driver enable, active high |
| tap_lo | output | 1 | Stored bit 0, always driven |
| tap_hi | output | 1 | Stored bit W-1, always driven |

## Verification
The bench targets four faults. It drives a load with both enables low: a design that keeps its drivers on during load would fight the incoming data, and `pad_oe` would read 1. It pulses clear in the middle of a cycle and holds it low across an edge that requests a load. A synchronous clear would leave the old word visible until that edge, and a wrong priority would let the load through. It also drives random modes, enables and serial bits against a bench model, which catches swapped shift directions, a serial input fed to the wrong end, and enables that wrongly gate the stored word. Finally it shifts a pair of chained instances both ways, which exposes taps wired to the wrong end.

// File: rtl/univ_shreg.sv
module univ_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         en_a_n,
  input  logic         en_b_n,
  input  logic         ser_rt,
  input  logic         ser_lf,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic         tap_lo,
  output logic         tap_hi
);
  localparam logic [1:0] M_HOLD = 2'b00;
  localparam logic [1:0] M_UP   = 2'b01;
  localparam logic [1:0] M_DN   = 2'b10;
  localparam logic [1:0] M_LD   = 2'b11;

  logic [W-1:0] st, nxt;
  logic         drive;

  always_comb begin
    case (mode)
      M_UP:    nxt = {st[W-2:0], ser_rt};
      M_DN:    nxt = {ser_lf, st[W-1:1]};
      M_LD:    nxt = pad_in;
      default: nxt = st;
    endcase
  end

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n) st <= '0;
    else        st <= nxt;

  assign drive   = !en_a_n && !en_b_n && (mode != M_LD);
  assign pad_oe  = {W{drive}};
  assign pad_out = st;
  assign tap_lo  = st[0];
  assign tap_hi  = st[W-1];

  p_hold_r1: assert property (@(posedge clk) disable iff (!clr_n)
    mode == M_HOLD |=> pad_out == $past(pad_out));
  p_up_r2: assert property (@(posedge clk) disable iff (!clr_n)
    mode == M_UP |=> pad_out == {$past(pad_out[W-2:0]), $past(ser_rt)});
  p_dn_r3: assert property (@(posedge clk) disable iff (!clr_n)
    mode == M_DN |=> pad_out == {$past(ser_lf), $past(pad_out[W-1:1])});
  p_load_r4: assert property (@(posedge clk) disable iff (!clr_n)
    mode == M_LD |=> pad_out == $past(pad_in));
  p_ld_off_r4: assert property (@(posedge clk) disable iff (!clr_n)
    mode == M_LD |-> pad_oe == '0);
  p_en_off_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (en_a_n || en_b_n) |-> pad_oe == '0);
  p_taps_r8: assert property (@(posedge clk) disable iff (!clr_n)
    tap_lo == pad_out[0] && tap_hi == pad_out[W-1]);
  always @(posedge clk)
    if (!clr_n) p_clr_r7: assert (pad_out == '0);
endmodule

// File: tb/tb_univ_shreg.sv
module tb_univ_shreg;
  localparam int W = 8;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic clr_n, en_a_n, en_b_n, ser_rt, ser_lf;
  logic [1:0] mode;
  logic [W-1:0] pad_in, pad_out, pad_oe;
  logic tap_lo, tap_hi;

  univ_shreg #(.W(W)) dut (.clk(clk), .clr_n(clr_n), .mode(mode), .en_a_n(en_a_n),
    .en_b_n(en_b_n), .ser_rt(ser_rt), .ser_lf(ser_lf), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .tap_lo(tap_lo), .tap_hi(tap_hi));

  logic [1:0] c_mode;
  logic c_sr, c_sl, lo_thi, hi_tlo, lo_tlo, hi_thi;
  logic [2*W-1:0] c_in;
  logic [W-1:0] lo_out, hi_out, lo_oe, hi_oe;
  univ_shreg #(.W(W)) c_lo (.clk(clk), .clr_n(clr_n), .mode(c_mode), .en_a_n(1'b0),
    .en_b_n(1'b0), .ser_rt(c_sr), .ser_lf(hi_tlo), .pad_in(c_in[W-1:0]),
    .pad_out(lo_out), .pad_oe(lo_oe), .tap_lo(lo_tlo), .tap_hi(lo_thi));
  univ_shreg #(.W(W)) c_hi (.clk(clk), .clr_n(clr_n), .mode(c_mode), .en_a_n(1'b0),
    .en_b_n(1'b0), .ser_rt(lo_thi), .ser_lf(c_sl), .pad_in(c_in[2*W-1:W]),
    .pad_out(hi_out), .pad_oe(hi_oe), .tap_lo(hi_tlo), .tap_hi(hi_thi));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [W-1:0] mdl;
  logic [2*W-1:0] cm;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] f_next(logic [1:0] m, logic [W-1:0] q,
      logic sr, logic sl, logic [W-1:0] d);
    case (m)
      2'b01: return {q[W-2:0], sr};
      2'b10: return {sl, q[W-1:1]};
      2'b11: return d;
      default: return q;
    endcase
  endfunction

  function automatic logic [W-1:0] f_oe(logic a, logic b, logic [1:0] m);
    return (!a && !b && m != 2'b11) ? {W{1'b1}} : '0;
  endfunction

  task automatic look(string tag);
    chk({tag, " R1/R2/R3/R4 word"}, 32'(pad_out), 32'(mdl));
    chk({tag, " R5 pad_oe"}, 32'(pad_oe), 32'(f_oe(en_a_n, en_b_n, mode)));
    chk({tag, " R8 taps"}, {30'd0, tap_hi, tap_lo}, {30'd0, mdl[W-1], mdl[0]});
  endtask

  task automatic tick(string tag);
    @(posedge clk); #1;
    mdl = f_next(mode, mdl, ser_rt, ser_lf, pad_in);
    look(tag);
  endtask

  task automatic ctick(string tag);
    @(posedge clk); #1;
    case (c_mode)
      2'b01: cm = {cm[2*W-2:0], c_sr};
      2'b10: cm = {c_sl, cm[2*W-1:1]};
      2'b11: cm = c_in;
      default: ;
    endcase
    chk({tag, " R10 chain"}, 32'({hi_out, lo_out}), 32'(cm));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clr_n = 0; mode = 0; en_a_n = 0; en_b_n = 0; ser_rt = 0; ser_lf = 0; pad_in = 0;
    c_mode = 0; c_sr = 0; c_sl = 0; c_in = 0; mdl = '0; cm = '0;
    @(posedge clk); #1;
    look("reset R7");
    clr_n = 1;
    mode = 2'b01; ser_rt = 1;
    tick("R9 first edge after clear");
    mode = 2'b11; pad_in = 8'h96;
    #0 chk("R4 drivers off in load", 32'(pad_oe), 32'd0);
    tick("R4 load enables low");
    mode = 2'b00; en_a_n = 1; pad_in = 8'h00;
    tick("R6 hold with enable high");
    mode = 2'b10; ser_lf = 1; en_b_n = 1;
    tick("R3 shift down enables high");
    mode = 2'b01; ser_rt = 0; en_a_n = 0; en_b_n = 0;
    tick("R2 shift up");
    mode = 2'b11; pad_in = 8'hFF; en_a_n = 1;
    clr_n = 0; #1;
    mdl = '0;
    chk("R7 async clear", 32'(pad_out), 32'd0);
    @(posedge clk); #1;
    chk("R7 edge ignored during clear", 32'(pad_out), 32'd0);
    clr_n = 1;
    mode = 2'b10; ser_lf = 1; en_a_n = 0;
    tick("R9 shift after clear");

    for (int i = 0; i < 3000; i++) begin
      mode = 2'($urandom); en_a_n = 1'($urandom); en_b_n = 1'($urandom);
      ser_rt = 1'($urandom); ser_lf = 1'($urandom); pad_in = W'($urandom);
      if ($urandom % 40 == 0) begin
        clr_n = 0; #1; mdl = '0;
        chk("R7 random clear", 32'(pad_out), 32'd0);
        @(posedge clk); #1;
        chk("R6 R7 clear held", 32'(pad_out), 32'd0);
        clr_n = 1;
      end else tick("random R6");
    end

    c_mode = 2'b11; c_in = 16'hA5C3; ctick("load");
    c_mode = 2'b01;
    for (int i = 0; i < 5; i++) begin c_sr = 1'(i & 1); ctick("shift up"); end
    c_mode = 2'b10;
    for (int i = 0; i < 7; i++) begin c_sl = 1'(~i & 1); ctick("shift down"); end
    c_mode = 2'b00; ctick("hold");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule